// File: doc/BRIEF.md
# PLL Lock Wait-and-Retry Sequencer

This block brings an external analog PLL into lock without software polling. After a start strobe it lets the PLL settle for a fixed number of clock cycles, then looks at the lock indication through a two-flop synchroniser. When lock is present the run ends at once. When it is absent the block issues a reset pulse to the PLL and, in the two-pulse style, a second pulse to the PLL's lock detector. It then waits and samples again, and it gives up after a bounded number of attempts.

The polarity of the PLL reset can be chosen. In normal polarity the line rests at 0 and pulses to 1. In negative polarity it rests at 1 and pulses to 0. The single-pulse style has no lock-detector pulse and takes the lock indication from a separate status input. Both choices are captured when a run starts and hold until the next start. The result stays visible until the next start: locked or failed, and how many reset pulses were issued.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset, pll_rst, det_rst, done, locked and fail are 0 and retries is 0.
- R2: A start accepted while idle captures neg_mode and single_style. From the next cycle pll_rst rests at its inactive level (0 when neg_mode was 0, 1 when it was 1) until a new start. Changing either input during a run has no effect.
- R3: Each attempt waits SETTLE_CYC cycles and then samples the synchronised lock indication. That indication is lock_main in the two-pulse style (single_style=0) and lock_alt in the single-pulse style (single_style=1). If it is 1, done and locked rise together in the next cycle.
- R4: With neg_mode=0, a failed attempt drives pll_rst to 1 for PULSE_CYC cycles, starting in the cycle after the sample.
- R5: With neg_mode=1, a failed attempt drives pll_rst to 0 for PULSE_CYC cycles.
- R6: In the two-pulse style, det_rst is 1 for the PULSE_CYC cycles that directly follow the PLL reset pulse. In the single-pulse style det_rst stays 0.
- R7: retries increases by one at the start of each PLL reset pulse. It therefore equals the number of pulses issued, is 0 when lock is seen at the first sample, and holds its value until the next start.
- R8: When MAX_TRIES attempts fail, done and fail rise together after the last reset pulse, retries equals MAX_TRIES, and locked stays 0.
- R9: A start strobe received while a run is in progress is ignored.
- R10: done is high for exactly one cycle per run. locked and fail hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lock sequence (accepted only when idle) |
| lock_main | input | 1 | PLL lock indication used in two-pulse style |
| lock_alt | input | 1 | Separate lock status input used in single-pulse style |
| neg_mode | input | 1 | 1 selects an active-low PLL reset pulse |
| single_style | input | 1 | 1 selects the single-pulse style |
| pll_rst | output | 1 | PLL reset line |
| det_rst | output | 1 | Lock-detector reset pulse |
| done | output | 1 | One-cycle end-of-run pulse |
| locked | output | 1 | Lock was seen in the last run |
| fail | output | 1 | Attempts ran out without lock |
| retries | output | TW | Number of PLL reset pulses issued in the last run |

## Verification
The bench targets lock found on the first sample, lock found on an intermediate attempt, and lock found on the very last permitted attempt. A design with an off-by-one attempt bound would report fail instead of locked in the last case, or issue an eleventh pulse. Exhaustion is run in both polarities and both styles. A design that inverted the idle level or skipped the detector pulse would show a wrong pll_rst or det_rst level in some cycle. The unused lock input is always driven to the opposite value, and the mode inputs are flipped in the middle of a run, so a design that read the wrong input or failed to latch the modes diverges at once. A start pulse injected during the settle wait shows whether a design restarts its timer or clears its count while busy.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PRST = 2'd2,
    ST_DRST = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= 1'b0;
          else     stg[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= 1'b0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pll_phase_timer.sv
module pll_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // phase ends on the edge that completes lim cycles
  assign hit = (cnt == lim - 1'b1);
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
  import pll_seq_pkg::*;
#(
  parameter int MAX_TRIES = 10,
  parameter int TW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          neg_mode,
  input  logic          single_style,
  input  logic          lock_s,
  input  logic          hit,
  output logic          tmr_clr,
  output logic          in_wait,
  output logic          sty_q,
  output logic          pol_q,
  output logic          pll_rst,
  output logic          det_rst,
  output logic          done,
  output logic          locked,
  output logic          fail,
  output logic [TW-1:0] retries
);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES);

  seq_state_e state;

  assign tmr_clr = (state == ST_IDLE) || hit;
  assign in_wait = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sty_q   <= 1'b0;
      pol_q   <= 1'b0;
      pll_rst <= 1'b0;
      det_rst <= 1'b0;
      done    <= 1'b0;
      locked  <= 1'b0;
      fail    <= 1'b0;
      retries <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_WAIT;
            pol_q   <= neg_mode;
            sty_q   <= single_style;
            pll_rst <= neg_mode;
            det_rst <= 1'b0;
            locked  <= 1'b0;
            fail    <= 1'b0;
            retries <= '0;
          end
        end
        ST_WAIT: begin
          if (hit) begin
            if (lock_s) begin
              state  <= ST_IDLE;
              done   <= 1'b1;
              locked <= 1'b1;
            end else begin
              state   <= ST_PRST;
              pll_rst <= ~pol_q;
              retries <= retries + 1'b1;
            end
          end
        end
        ST_PRST: begin
          if (hit) begin
            pll_rst <= pol_q;
            if (!sty_q) begin
              state   <= ST_DRST;
              det_rst <= 1'b1;
            end else if (retries == LAST_TRY) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              fail  <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_DRST: begin
          if (hit) begin
            det_rst <= 1'b0;
            if (retries == LAST_TRY) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              fail  <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq #(
  parameter int SETTLE_CYC  = 6250,
  parameter int PULSE_CYC   = 4,
  parameter int MAX_TRIES   = 10,
  parameter int SYNC_STAGES = 2,
  localparam int TW         = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          lock_main,
  input  logic          lock_alt,
  input  logic          neg_mode,
  input  logic          single_style,
  output logic          pll_rst,
  output logic          det_rst,
  output logic          done,
  output logic          locked,
  output logic          fail,
  output logic [TW-1:0] retries
);
  localparam int LONGEST = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] SETTLE_L = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] PULSE_L  = CW'(PULSE_CYC);

  logic          sty_q;
  logic          pol_q;
  logic          lock_s;
  logic          hit;
  logic          tmr_clr;
  logic          in_wait;
  logic [CW-1:0] lim;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sty_q ? lock_alt : lock_main),
    .q   (lock_s)
  );

  assign lim = in_wait ? SETTLE_L : PULSE_L;

  pll_phase_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .lim (lim),
    .hit (hit)
  );

  pll_lock_fsm #(.MAX_TRIES(MAX_TRIES), .TW(TW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .neg_mode     (neg_mode),
    .single_style (single_style),
    .lock_s       (lock_s),
    .hit          (hit),
    .tmr_clr      (tmr_clr),
    .in_wait      (in_wait),
    .sty_q        (sty_q),
    .pol_q        (pol_q),
    .pll_rst      (pll_rst),
    .det_rst      (det_rst),
    .done         (done),
    .locked       (locked),
    .fail         (fail),
    .retries      (retries)
  );
endmodule

// File: rtl/pll_lock_seq_chk.sv
module pll_lock_seq_chk #(
  parameter int MAX_TRIES = 10,
  parameter int TW        = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          locked,
  input logic          fail,
  input logic          pll_rst,
  input logic          det_rst,
  input logic          sty_q,
  input logic          pol_q,
  input logic [TW-1:0] retries
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |-> (locked != fail)); // R3

  AST_LOCKED_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(locked && fail)); // R8

  AST_SINGLE_NO_DET: assert property (@(posedge clk) disable iff (rst)
    sty_q |-> !det_rst); // R6

  AST_PULSES_APART: assert property (@(posedge clk) disable iff (rst)
    det_rst |-> (pll_rst == pol_q)); // R6

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    retries <= TW'(MAX_TRIES)); // R7

  AST_RETRY_STEP: assert property (@(posedge clk) disable iff (rst)
    (retries == $past(retries)) || (retries == $past(retries) + 1'b1) || (retries == '0)); // R7
endmodule

bind pll_lock_seq pll_lock_seq_chk #(.MAX_TRIES(MAX_TRIES), .TW(TW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .locked  (locked),
  .fail    (fail),
  .pll_rst (pll_rst),
  .det_rst (det_rst),
  .sty_q   (sty_q),
  .pol_q   (pol_q),
  .retries (retries)
);

// File: tb/test_pll_lock_seq.sv
module test_pll_lock_seq;
  localparam int S  = 12;
  localparam int P  = 3;
  localparam int MX = 10;
  localparam int TW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic lock_main = 1'b0;
  logic lock_alt = 1'b0;
  logic neg_mode = 1'b0;
  logic single_style = 1'b0;
  logic pll_rst, det_rst, done, locked, fail;
  logic [TW-1:0] retries;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pll_lock_seq #(.SETTLE_CYC(S), .PULSE_CYC(P), .MAX_TRIES(MX)) i_pll_lock_seq (
    .clk(clk), .rst(rst), .start(start), .lock_main(lock_main), .lock_alt(lock_alt),
    .neg_mode(neg_mode), .single_style(single_style), .pll_rst(pll_rst),
    .det_rst(det_rst), .done(done), .locked(locked), .fail(fail), .retries(retries)
  );

  typedef struct {
    bit lk;
    bit pll;
    bit det;
    bit dn;
    bit lkd;
    bit fl;
    int ret;
  } exp_t;

  exp_t q[$];

  task automatic check(input exp_t e, input string run, input bit neg);
    bit bad = 0;
    compared++;
    if (pll_rst !== e.pll) begin
      bad = 1;
      $display("FAIL %s run=%s pll_rst act=%0b exp=%0b", neg ? "R5/R2" : "R4/R2", run, pll_rst, e.pll);
    end
    if (det_rst !== e.det) begin
      bad = 1;
      $display("FAIL R6 run=%s det_rst act=%0b exp=%0b", run, det_rst, e.det);
    end
    if (done !== e.dn) begin
      bad = 1;
      $display("FAIL R3/R10 run=%s done act=%0b exp=%0b", run, done, e.dn);
    end
    if (locked !== e.lkd) begin
      bad = 1;
      $display("FAIL R3 run=%s locked act=%0b exp=%0b", run, locked, e.lkd);
    end
    if (fail !== e.fl) begin
      bad = 1;
      $display("FAIL R8 run=%s fail act=%0b exp=%0b", run, fail, e.fl);
    end
    if (int'(retries) !== e.ret) begin
      bad = 1;
      $display("FAIL R7 run=%s retries act=%0d exp=%0d", run, retries, e.ret);
    end
    if (bad) mismatched++;
  endtask

  // lock_at: attempt number where lock is present (0 = never); inject: cycle of a busy start (-1 = none)
  task automatic run(input string name, input int lock_at, input bit neg, input bit single, input int inject);
    exp_t e;
    exp_t last;
    q.delete();
    for (int a = 1; a <= MX; a++) begin
      for (int i = 0; i < S; i++) begin
        e = '{lk: (a == lock_at), pll: neg, det: 0, dn: 0, lkd: 0, fl: 0, ret: a - 1};
        q.push_back(e);
      end
      if (a == lock_at) begin
        e = '{lk: 0, pll: neg, det: 0, dn: 1, lkd: 1, fl: 0, ret: a - 1};
        q.push_back(e);
        break;
      end
      for (int i = 0; i < P; i++) begin
        e = '{lk: 1, pll: !neg, det: 0, dn: 0, lkd: 0, fl: 0, ret: a};
        q.push_back(e);
      end
      if (!single) begin
        for (int i = 0; i < P; i++) begin
          e = '{lk: 1, pll: neg, det: 1, dn: 0, lkd: 0, fl: 0, ret: a};
          q.push_back(e);
        end
      end
      if (a == MX) begin
        e = '{lk: 0, pll: neg, det: 0, dn: 1, lkd: 0, fl: 1, ret: a};
        q.push_back(e);
      end
    end
    last = q[$];
    last.dn = 0;
    last.lk = 0;
    for (int i = 0; i < 3; i++) q.push_back(last);

    @(negedge clk);
    start = 1'b1;
    neg_mode = neg;
    single_style = single;
    @(posedge clk);
    for (int j = 0; j < q.size(); j++) begin
      @(negedge clk);
      start = (j == inject);
      if (j == 2) begin
        neg_mode = !neg;          // R2: ignored mid-run
        single_style = !single;
      end
      lock_main = single ? !q[j].lk : q[j].lk;
      lock_alt  = single ? q[j].lk : !q[j].lk;
      check(q[j], name, neg);
    end
    start = 1'b0;
  endtask

  initial begin
    exp_t z;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    z = '{lk: 0, pll: 0, det: 0, dn: 0, lkd: 0, fl: 0, ret: 0};
    check(z, "reset_R1", 1'b0);

    run("first_try_R3", 1, 1'b0, 1'b0, -1);
    run("fourth_try_R4_R6", 4, 1'b0, 1'b0, -1);
    run("neg_third_R5", 3, 1'b1, 1'b0, -1);
    run("single_alt_R6", 2, 1'b0, 1'b1, -1);
    run("exhaust_R8", 0, 1'b0, 1'b0, -1);
    run("neg_single_exhaust_R8", 0, 1'b1, 1'b1, -1);
    run("last_try_R7", MX, 1'b1, 1'b0, -1);
    run("busy_start_R9", 3, 1'b0, 1'b0, 5);
    run("busy_start_pulse_R9", 2, 1'b1, 1'b1, S + 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule